// File: doc/BRIEF.md
# Strobed Host Register Port

This block is the device side of a parallel host bus with separate read and write strobes and a multiplexed address phase. The host presents a 9-bit byte address and raises an address-latch strobe, with chip select held low. The port follows the address while that strobe is high and keeps it once the strobe falls. A low read strobe turns on the 16-bit data bus drivers with the word or byte found at the held address. A low write strobe stores bus data into the addressed register when the strobe returns high.

A ready output gives the handshake. Ready falls as soon as a strobe goes low with chip select low. It rises after a parameterised number of internal clocks, and it goes back high when the strobe is released. All host strobes are brought into the internal clock domain through two-flop synchronizers.

A mode pin selects between two bus widths:
- In 16-bit mode, accesses are word-wide and address bit 0 is ignored.
- In 8-bit mode, address bit 0 selects the byte lane.

A free-running 16-bit event counter sits in the address map. In 8-bit mode, a high-byte holding register keeps the two halves of one counter reading consistent.

Top module: `strobe_bus_slave`

## Requirements
- R1: After reset, ready is high and every general register reads as zero.
- R2: While chip select is high, read and write strobes have no effect: ready stays high and no register changes.
- R3: The address is taken while the address-latch strobe is high (with chip select low). Changes on the address pins after that strobe falls do not affect the access.
- R4: Ready goes low in the same instant that a read or write strobe goes low while chip select is low, with no clock edge needed.
- R5: Ready rises no sooner than WAIT_CYC clocks and no later than WAIT_CYC+3 clocks after the strobe falls. It is high again as soon as the strobe is released.
- R6: In 16-bit mode, a read returns the whole word at word index addr[8:1], and addr[0] has no effect. The data is valid while ready is high.
- R7: In 8-bit mode, a read with addr[0]=0 returns the low byte of the word on data[7:0], and addr[0]=1 returns the high byte there. data[15:8] reads as zero.
- R8: A write stores data into the register at the rising edge of the write strobe. In 16-bit mode the whole word is stored. In 8-bit mode only data[7:0] is stored, into the lane chosen by addr[0]; data[15:8] is ignored.
- R9: Word index CNT_IDX (default 16, byte addresses 0x020/0x021) holds a 16-bit counter. It increments on each clock with the event input high. Writes to it are ignored.
- R10: In 8-bit mode, a read of the counter low byte copies the counter high byte into a holding register. A read of the counter high byte returns the held copy. In 16-bit mode, the counter is read whole, as it stands when the read begins.
- R11: Word indices that are neither a general register (0 to NREGS-1) nor the counter read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 selects 16-bit mode, 0 selects 8-bit mode |
| cs_n_i | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address-latch strobe, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 9 | Byte address |
| data_io | inout | 16 | Bidirectional data bus |
| evt_i | input | 1 | Counter increment event |
| rdy_o | output | 1 | Ready handshake, low means wait |

## Verification
The fall of ready is combinational, so the bench samples it 1 ns after it drives a strobe low, and again 1 ns after it releases the strobe. The rise of ready is due two synchronizer clocks plus WAIT_CYC wait-counter clocks after the strobe, that is WAIT_CYC+2 clocks. The bench counts falling clock edges from the strobe to the first high ready and accepts WAIT_CYC to WAIT_CYC+3. Read data is sampled only once ready is high. A write is checked by a later read, after the synchronized strobe release has had several clocks to commit it.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic cs_n;
    logic ale;
    logic rd_n;
    logic wr_n;
  } strobe_t;

  localparam logic [3:0] STROBE_IDLE = 4'b1011;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hb_wait.sv
module hb_wait #(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic rdy_q
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!act)
      cnt_d = '0;
    else if (cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
    rdy_d = act && (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  // R5: ready only follows a cycle in which an access was active
  a_r5_rdy_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $past(act));

  // R5: no ready on the first active cycle
  a_r5_no_early_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |=> !rdy_q);
endmodule

// File: rtl/hb_regs.sv
module hb_regs #(
  parameter int AW      = 9,
  parameter int DW      = 16,
  parameter int NREGS   = 8,
  parameter int CNT_IDX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic [AW-1:0] addr_q,
  input  logic          rd_start,
  input  logic          wr_commit,
  input  logic [DW-1:0] wdata,
  input  logic          evt,
  output logic [DW-1:0] rd_word
);
  localparam int WAW = AW - 1;
  localparam int HB  = DW / 2;
  localparam int IW  = $clog2(NREGS);

  logic [WAW-1:0]      word;
  logic                lane;
  logic [NREGS*DW-1:0] flat;
  logic [DW-1:0]       pm_q, pm_d;
  logic [HB-1:0]       hold_q, hold_d;
  logic [DW-1:0]       rd_word_q, rd_word_d;
  logic [DW-1:0]       full;
  logic                is_cnt, is_reg;

  assign word   = addr_q[AW-1:1];
  assign lane   = addr_q[0];
  assign is_cnt = (word == WAW'(CNT_IDX));
  assign is_reg = (word < WAW'(NREGS));

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DW-1:0] val_q, val_d;
    logic          hit;

    assign hit = wr_commit && (word == WAW'(i));

    always_comb begin
      val_d = val_q;
      if (hit) begin
        if (wide)
          val_d = wdata;
        else if (lane)
          val_d[DW-1:HB] = wdata[HB-1:0];
        else
          val_d[HB-1:0] = wdata[HB-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign flat[i*DW +: DW] = val_q;
  end

  always_comb begin
    pm_d   = pm_q + DW'(evt);
    hold_d = hold_q;
    if (rd_start && !wide && is_cnt && !lane)
      hold_d = pm_q[DW-1:HB];
  end

  always_comb begin
    if (is_cnt)
      full = pm_q;
    else if (is_reg)
      full = flat[DW*int'(word[IW-1:0]) +: DW];
    else
      full = '0;

    rd_word_d = rd_word_q;
    if (rd_start) begin
      if (wide)
        rd_word_d = full;
      else if (is_cnt && lane)
        rd_word_d = {{HB{1'b0}}, hold_q};
      else if (lane)
        rd_word_d = {{HB{1'b0}}, full[DW-1:HB]};
      else
        rd_word_d = {{HB{1'b0}}, full[HB-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q      <= '0;
      hold_q    <= '0;
      rd_word_q <= '0;
    end else begin
      pm_q      <= pm_d;
      hold_q    <= hold_d;
      rd_word_q <= rd_word_d;
    end
  end

  assign rd_word = rd_word_q;

  // R9: the counter only ever steps by one; host writes never land in it
  a_r9_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pm_q) |-> pm_q == $past(pm_q) + DW'(1));

  // R10: the holding register is only ever loaded from the counter high byte
  a_r10_hold_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_q) |-> hold_q == $past(pm_q[DW-1:HB]));

  // R7: a byte-mode read leaves the upper lane zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_start) && !$past(wide)) |-> rd_word_q[DW-1:HB] == '0);
endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave #(
  parameter int AW       = 9,
  parameter int DW       = 16,
  parameter int NREGS    = 8,
  parameter int CNT_IDX  = 16,
  parameter int WAIT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_i,
  input  logic          cs_n_i,
  input  logic          ale_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  inout  wire  [DW-1:0] data_io,
  input  logic          evt_i,
  output logic          rdy_o
);
  import hb_pkg::*;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  strobe_t       raw, syn;
  logic [3:0]    syn_bits;
  logic          act_rd, act_wr, act;
  logic          rd_prev_q, wr_prev_q;
  logic          rd_start, wr_commit;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rd_word;
  logic          rdy_q;
  logic          strobe_raw;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign raw = '{cs_n: cs_n_i, ale: ale_i, rd_n: rd_n_i, wr_n: wr_n_i};

  hb_sync #(.W(4), .RST_VAL(STROBE_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw),
    .q     (syn_bits)
  );
  assign syn = strobe_t'(syn_bits);

  assign act_rd    = !syn.cs_n && !syn.rd_n;
  assign act_wr    = !syn.cs_n && !syn.wr_n;
  assign act       = act_rd || act_wr;
  assign rd_start  = act_rd && !rd_prev_q;
  assign wr_commit = wr_prev_q && syn.wr_n && !syn.cs_n;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (syn.ale && !syn.cs_n)
      addr_d = addr_i;
    if (act_wr)
      wdata_d = data_io;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      rd_prev_q <= act_rd;
      wr_prev_q <= act_wr;
    end
  end

  hb_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk   (clk),
    .rst_n (rst_int_n),
    .act   (act),
    .rdy_q (rdy_q)
  );

  hb_regs #(.AW(AW), .DW(DW), .NREGS(NREGS), .CNT_IDX(CNT_IDX)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wide      (wide_i),
    .addr_q    (addr_q),
    .rd_start  (rd_start),
    .wr_commit (wr_commit),
    .wdata     (wdata_q),
    .evt       (evt_i),
    .rd_word   (rd_word)
  );

  assign strobe_raw = !cs_n_i && (!rd_n_i || !wr_n_i);
  assign rdy_o      = strobe_raw ? rdy_q : 1'b1;
  assign data_io    = act_rd ? rd_word : {DW{1'bz}};

  // R3: once the latch strobe is seen low, the held address does not move
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    !syn.ale |=> $stable(addr_q));

  // R4: a raw strobe not yet seen by the clock domain already pulls ready low
  a_r4_rdy_drops: assert property (@(posedge clk) disable iff (!rst_int_n)
    (strobe_raw && !act) |-> !rdy_o);

  // R2: with chip select held high, no wait-state completion is reported
  a_r2_cs_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (syn.cs_n && $past(syn.cs_n)) |-> !rdy_q);

  // R2: bus drivers only on with chip select low
  a_r2_drive_needs_cs: assert property (@(posedge clk) disable iff (!rst_int_n)
    act_rd |-> !syn.cs_n);
endmodule

// File: tb/strobe_bus_slave_test.sv
module strobe_bus_slave_test;
  localparam int CLK_PER = 10;
  localparam int WAITC   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide, cs_n, ale, rd_n, wr_n, evt;
  logic [8:0]  addr;
  logic        tb_oe;
  logic [15:0] tb_dat;
  wire  [15:0] bus;
  logic        rdy;
  int          n_chk = 0;
  int          n_fail = 0;

  assign bus = tb_oe ? tb_dat : 16'hzzzz;

  always #(CLK_PER/2) clk = ~clk;

  strobe_bus_slave #(.WAIT_CYC(WAITC)) uut (
    .clk(clk), .rst_n(rst_n), .wide_i(wide), .cs_n_i(cs_n), .ale_i(ale),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr), .data_io(bus),
    .evt_i(evt), .rdy_o(rdy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit is_wr, input bit sel, input logic [8:0] a,
                           input logic [8:0] a_late, input logic [15:0] wd,
                           output logic [15:0] rv);
    int waits;
    bit stay_hi;
    rv = '0;
    @(negedge clk);
    cs_n = !sel; ale = 1'b1; addr = a;
    if (is_wr) begin tb_oe = 1'b1; tb_dat = wd; end
    repeat (4) @(negedge clk);
    ale = 1'b0;
    repeat (3) @(negedge clk);
    addr = a_late;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    if (sel) begin
      chk("R4 ready low at strobe", {15'd0, rdy}, 16'd0);
      waits = 0;
      while (waits < 40) begin
        @(negedge clk);
        waits++;
        if (rdy) break;
      end
      chk("R5 ready delay in window", {15'd0, (waits >= WAITC && waits <= WAITC + 3)}, 16'd1);
      if (!is_wr) rv = bus;
    end else begin
      stay_hi = 1'b1;
      repeat (WAITC + 6) begin
        @(negedge clk);
        if (!rdy) stay_hi = 1'b0;
      end
      chk("R2 ready stays high without chip select", {15'd0, stay_hi}, 16'd1);
    end
    rd_n = 1'b1; wr_n = 1'b1;
    #1;
    if (sel) chk("R5 ready high on release", {15'd0, rdy}, 16'd1);
    repeat (4) @(negedge clk);
    tb_oe = 1'b0; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    bus_cycle(1'b1, 1'b1, a, a, d, dummy);
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] v);
    bus_cycle(1'b0, 1'b1, a, a, 16'h0, v);
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt = 1'b1;
    repeat (k) @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 ready high after reset", {15'd0, rdy}, 16'd1);
    wide = 1'b1;
    rd(9'h000, v); chk("R1 reg0 zero after reset", v, 16'h0000);
    rd(9'h00E, v); chk("R1 reg7 zero after reset", v, 16'h0000);
  endtask

  task automatic t_wide();
    logic [15:0] v;
    wide = 1'b1;
    wr(9'h006, 16'hBEEF);
    rd(9'h006, v); chk("R6 R8 word read back", v, 16'hBEEF);
    rd(9'h007, v); chk("R6 addr0 ignored", v, 16'hBEEF);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    logic [15:0] dummy;
    wide = 1'b1;
    bus_cycle(1'b0, 1'b1, 9'h006, 9'h000, 16'h0, v);
    chk("R3 read uses latched address", v, 16'hBEEF);
    bus_cycle(1'b1, 1'b1, 9'h002, 9'h006, 16'h4444, dummy);
    rd(9'h006, v); chk("R3 late address not written", v, 16'hBEEF);
    rd(9'h002, v); chk("R3 latched address written", v, 16'h4444);
  endtask

  task automatic t_narrow();
    logic [15:0] v;
    wide = 1'b1; wr(9'h00A, 16'h1122);
    wide = 1'b0; wr(9'h00B, 16'h77A5);
    wide = 1'b1; rd(9'h00A, v); chk("R8 byte write high lane only", v, 16'hA522);
    wide = 1'b0; wr(9'h00A, 16'hFF3C);
    wide = 1'b1; rd(9'h00A, v); chk("R8 byte write low lane only", v, 16'hA53C);
    wide = 1'b0;
    rd(9'h00A, v); chk("R7 low byte read", v, 16'h003C);
    rd(9'h00B, v); chk("R7 high byte read", v, 16'h00A5);
  endtask

  task automatic t_cs();
    logic [15:0] v;
    logic [15:0] dummy;
    wide = 1'b1;
    bus_cycle(1'b1, 1'b0, 9'h006, 9'h006, 16'h0000, dummy);
    rd(9'h006, v); chk("R2 write ignored without chip select", v, 16'hBEEF);
    bus_cycle(1'b0, 1'b0, 9'h006, 9'h006, 16'h0, dummy);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wide = 1'b1;
    rd(9'h014, v); chk("R11 unmapped reads zero", v, 16'h0000);
    wr(9'h014, 16'h5A5A);
    rd(9'h014, v); chk("R11 unmapped write ignored", v, 16'h0000);
    rd(9'h000, v); chk("R11 reg0 untouched", v, 16'h0000);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    wide = 1'b1;
    pulse(16'h1234);
    rd(9'h020, v); chk("R9 counter word", v, 16'h1234);
    rd(9'h021, v); chk("R9 counter word addr0 ignored", v, 16'h1234);
    wr(9'h020, 16'hFFFF);
    rd(9'h020, v); chk("R9 counter write ignored", v, 16'h1234);
    wide = 1'b0;
    rd(9'h020, v); chk("R10 counter low byte", v, 16'h0034);
    pulse(16'h0100);
    rd(9'h021, v); chk("R10 high byte from hold", v, 16'h0012);
    wide = 1'b1;
    rd(9'h020, v); chk("R10 wide read is live", v, 16'h1334);
    wide = 1'b0;
    rd(9'h020, v); chk("R10 low byte again", v, 16'h0034);
    rd(9'h021, v); chk("R10 hold refreshed", v, 16'h0013);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wide = 1'b1; cs_n = 1'b1; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    evt = 1'b0; addr = '0; tb_oe = 1'b0; tb_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wide();
    t_latch();
    t_narrow();
    t_cs();
    t_unmapped();
    t_counter();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule